// File: doc/BRIEF.md
# Fuse Array Programming Controller

This block controls a one-time-programmable fuse store of 8 banks, each holding 256 byte-wide words. Software reaches it over a small register bus with an address, write and read strobes, and byte-wide data. It can burn one fuse bit at a time, sense a whole fuse word into a data register, and read or override a shadow copy of any word through an address window.

Each program or sense operation holds a busy flag for a fixed number of clocks. At the end it sets a sticky done bit or an error bit, and software clears these by writing ones. A program request takes effect only when a key register holds the unlock value. Each bank can be protected from programming, from reads through the window, or from overrides; these protections are fixed by parameters.

After reset the controller copies every fuse word into the shadow store and shows busy while it does so. Burned fuses keep their value across resets. Overrides change only the shadow copy.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset, the status register (offset 0x0) reads 0x80 while the shadow store is loaded from the fuses. Afterwards status reads 0x00, the error register (offset 0x2) reads 0x00, and every shadow word equals its fuse word.
- R2: The target location comes from two registers. The upper address register (offset 0x5) holds the bank in bits 5:3 and row bits 7:5 in bits 2:0. The lower address register (offset 0x6) holds row bits 4:0 in bits 7:3 and the bit index in bits 2:0. A program cycle burns only that one bit.
- R3: Writing bit 0 of the function register (offset 0x4) starts a program cycle only if the key register (offset 0x8) holds 0xAA. Without the key, error bit 7 is set on the next cycle, busy never rises and the fuses are unchanged.
- R4: A program request aimed at a write-protected bank (default bank 7) sets error bit 6 and leaves the fuses unchanged.
- R5: Status bit 7 stays high for exactly PROG_CYCLES clocks after a program start, or SENSE_CYCLES clocks after a sense start. In the clock where it falls, status bit 1 (program) or bit 0 (sense) is set.
- R6: Writing bit 3 of the function register starts a sense of the addressed word, and on completion the sense-data register (offset 0x7) holds that fuse word. For a read-protected bank, error bit 2 is set instead and sense data is unchanged.
- R7: Programming can only turn bits to 1. Programming a burned bit again changes nothing, and burned bits survive reset.
- R8: An access with address bit 11 set goes to the shadow window, with the bank in address bits 10:8 and the word in bits 7:0. A write replaces the shadow word and does not touch the fuses.
- R9: A window read of a read-protected bank (default bank 6) returns 0x00 and sets error bit 4.
- R10: A window write to an override-protected bank (default bank 5) sets error bit 5 and leaves the shadow word unchanged.
- R11: The status done bits and the error bits clear when a one is written to them. If a clear and a new set of the same bit fall in the same clock, the bit ends up set.
- R12: While busy, writes to the address, key and function registers and to the window are ignored and start nothing.
- R13: Function register bits 7:4 (program length and program-clock disable) are stored and read back. The start bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register offset (bit 11 clear) or window bank/word (bit 11 set) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata one clock later |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
Two things can hit the same sticky bit in the same clock: the end of a program cycle sets the done bit, and a software write-one-to-clear of that bit lands on that very edge. The bench starts a program cycle, counts exactly PROG_CYCLES clocks, and issues the clear on the completion edge. It then expects the done bit to read back as 1. A second clear one clock later must bring it to 0, which shows the set won the tie and the clear itself works.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 8;
    localparam int BIT_W  = 3;
    localparam int IDX_W  = BANK_W + ROW_W;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int NBANKS = 1 << BANK_W;
    localparam int ADDR_W = IDX_W + 1;

    localparam logic [7:0] PROG_KEY = 8'hAA;

    localparam logic [3:0] OFS_STAT  = 4'h0;
    localparam logic [3:0] OFS_STATM = 4'h1;
    localparam logic [3:0] OFS_ERR   = 4'h2;
    localparam logic [3:0] OFS_ERRM  = 4'h3;
    localparam logic [3:0] OFS_FCTL  = 4'h4;
    localparam logic [3:0] OFS_UA    = 4'h5;
    localparam logic [3:0] OFS_LA    = 4'h6;
    localparam logic [3:0] OFS_SDAT  = 4'h7;
    localparam logic [3:0] OFS_KEY   = 4'h8;

    localparam int ST_PRGD = 1;
    localparam int ST_SNSD = 0;
    localparam int ER_PRG  = 7;
    localparam int ER_WP   = 6;
    localparam int ER_OVR  = 5;
    localparam int ER_RD   = 4;
    localparam int ER_SNS  = 2;
    localparam int FC_PRG  = 0;
    localparam int FC_SNS  = 3;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [BIT_W-1:0]  bitn;
    } fuse_loc_t;

    typedef enum logic [1:0] {OP_IDLE, OP_LOAD, OP_SENSE, OP_PROG} op_e;

    function automatic fuse_loc_t decode_loc(input logic [7:0] ua, input logic [7:0] la);
        fuse_loc_t l;
        l.bank = ua[5:3];
        l.row  = {ua[2:0], la[7:3]};
        l.bitn = la[2:0];
        return l;
    endfunction
endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int PROG_CYCLES  = 64,
    parameter int SENSE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_prog,
    input  logic             start_sense,
    output logic             busy,
    output logic             fin_prog,
    output logic             fin_sense,
    output logic             load_we,
    output logic [IDX_W-1:0] load_idx
);
    localparam int OP_MAX  = (PROG_CYCLES > SENSE_CYCLES) ? PROG_CYCLES : SENSE_CYCLES;
    localparam int LONGEST = (OP_MAX > DEPTH) ? OP_MAX : DEPTH;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    op_e              op_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last      = (cnt_q == '0);
    assign busy      = (op_q != OP_IDLE);
    assign fin_prog  = (op_q == OP_PROG) && last;
    assign fin_sense = (op_q == OP_SENSE) && last;
    assign load_we   = (op_q == OP_LOAD);
    assign load_idx  = cnt_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_LOAD;
            cnt_q <= CNT_W'(DEPTH - 1);
        end else begin
            case (op_q)
                OP_IDLE: begin
                    if (start_prog) begin
                        op_q  <= OP_PROG;
                        cnt_q <= CNT_W'(PROG_CYCLES - 1);
                    end else if (start_sense) begin
                        op_q  <= OP_SENSE;
                        cnt_q <= CNT_W'(SENSE_CYCLES - 1);
                    end
                end
                default: begin
                    if (last) op_q <= OP_IDLE;
                    else      cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/fuse_store.sv
module fuse_store
    import fuse_pkg::*;
(
    input  logic             clk,
    input  logic             burn_en,
    input  logic [IDX_W-1:0] burn_idx,
    input  logic [BIT_W-1:0] burn_bit,
    input  logic [IDX_W-1:0] fuse_idx,
    output logic [7:0]       fuse_rdata,
    input  logic             sh_we,
    input  logic [IDX_W-1:0] sh_widx,
    input  logic [7:0]       sh_wdata,
    input  logic [IDX_W-1:0] sh_ridx,
    output logic [7:0]       sh_rdata
);
    // Fuse cells are non-volatile: no reset clears them.
    logic [7:0] fuse_mem   [DEPTH];
    logic [7:0] shadow_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (burn_en) fuse_mem[burn_idx] <= fuse_mem[burn_idx] | (8'h01 << burn_bit);
    end

    always_ff @(posedge clk) begin
        if (sh_we) shadow_mem[sh_widx] <= sh_wdata;
    end

    assign fuse_rdata = fuse_mem[fuse_idx];
    assign sh_rdata   = shadow_mem[sh_ridx];
endmodule

// File: rtl/fuse_regs.sv
module fuse_regs
    import fuse_pkg::*;
#(
    parameter logic [NBANKS-1:0] WP_BANKS = 8'h80,
    parameter logic [NBANKS-1:0] RP_BANKS = 8'h40,
    parameter logic [NBANKS-1:0] OP_BANKS = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              busy,
    input  logic              fin_prog,
    input  logic              fin_sense,
    input  logic [7:0]        fuse_word,
    input  logic [7:0]        sh_rdata,
    output logic              start_prog,
    output logic              start_sense,
    output fuse_loc_t         loc,
    output logic              win_we,
    output logic [IDX_W-1:0]  win_idx,
    output logic [7:0]        win_wdata,
    output logic [7:0]        key_q,
    output logic [7:0]        ua_q,
    output logic [1:0]        stat_q,
    output logic [7:0]        err_q
);
    logic [7:0] la_q, statm_q, errm_q, sdat_q;
    logic [3:0] fctl_q;
    logic [7:0] err_set, w1c_err;
    logic [1:0] stat_set, w1c_stat;

    logic              is_win, reg_wr, ctl_wr, fctl_wr, want_prog;
    logic              key_ok, bank_wp, sense_blocked, ovr_hit, rd_hit;
    logic [3:0]        ofs;
    logic [BANK_W-1:0] win_bank;

    assign is_win   = bus_addr[ADDR_W-1];
    assign ofs      = bus_addr[3:0];
    assign win_idx  = bus_addr[IDX_W-1:0];
    assign win_bank = bus_addr[IDX_W-1:ROW_W];
    assign reg_wr   = bus_wr && !is_win;
    assign ctl_wr   = reg_wr && !busy;
    assign fctl_wr  = ctl_wr && (ofs == OFS_FCTL);
    assign loc      = decode_loc(ua_q, la_q);

    assign want_prog     = fctl_wr && bus_wdata[FC_PRG];
    assign key_ok        = (key_q == PROG_KEY);
    assign bank_wp       = WP_BANKS[loc.bank];
    assign sense_blocked = RP_BANKS[loc.bank];
    assign start_prog    = want_prog && key_ok && !bank_wp;
    assign start_sense   = fctl_wr && bus_wdata[FC_SNS] && !bus_wdata[FC_PRG];

    assign win_we    = bus_wr && is_win && !busy && !OP_BANKS[win_bank];
    assign win_wdata = bus_wdata;
    assign ovr_hit   = bus_wr && is_win && !busy && OP_BANKS[win_bank];
    assign rd_hit    = bus_rd && is_win && RP_BANKS[win_bank];

    always_comb begin
        err_set         = '0;
        err_set[ER_PRG] = want_prog && !key_ok;
        err_set[ER_WP]  = want_prog && bank_wp;
        err_set[ER_OVR] = ovr_hit;
        err_set[ER_RD]  = rd_hit;
        err_set[ER_SNS] = fin_sense && sense_blocked;
        stat_set          = '0;
        stat_set[ST_PRGD] = fin_prog;
        stat_set[ST_SNSD] = fin_sense && !sense_blocked;
        w1c_err  = (reg_wr && ofs == OFS_ERR)  ? bus_wdata      : 8'h00;
        w1c_stat = (reg_wr && ofs == OFS_STAT) ? bus_wdata[1:0] : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            err_q   <= '0;
            statm_q <= '0;
            errm_q  <= '0;
            ua_q    <= '0;
            la_q    <= '0;
            key_q   <= '0;
            fctl_q  <= '0;
            sdat_q  <= '0;
        end else begin
            // a set in the same clock as a clear wins
            stat_q <= (stat_q & ~w1c_stat) | stat_set;
            err_q  <= (err_q & ~w1c_err) | err_set;
            if (reg_wr && ofs == OFS_STATM) statm_q <= bus_wdata;
            if (reg_wr && ofs == OFS_ERRM)  errm_q  <= bus_wdata;
            if (ctl_wr && ofs == OFS_UA)    ua_q    <= bus_wdata;
            if (ctl_wr && ofs == OFS_LA)    la_q    <= bus_wdata;
            if (ctl_wr && ofs == OFS_KEY)   key_q   <= bus_wdata;
            if (fctl_wr)                    fctl_q  <= bus_wdata[7:4];
            if (fin_sense && !sense_blocked) sdat_q <= fuse_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (is_win) begin
                bus_rdata <= RP_BANKS[win_bank] ? 8'h00 : sh_rdata;
            end else begin
                case (ofs)
                    OFS_STAT:  bus_rdata <= {busy, 5'b0, stat_q};
                    OFS_STATM: bus_rdata <= statm_q;
                    OFS_ERR:   bus_rdata <= err_q;
                    OFS_ERRM:  bus_rdata <= errm_q;
                    OFS_FCTL:  bus_rdata <= {fctl_q, 4'b0};
                    OFS_UA:    bus_rdata <= ua_q;
                    OFS_LA:    bus_rdata <= la_q;
                    OFS_SDAT:  bus_rdata <= sdat_q;
                    OFS_KEY:   bus_rdata <= key_q;
                    default:   bus_rdata <= 8'h00;
                endcase
            end
        end
    end
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
    import fuse_pkg::*;
#(
    parameter int                PROG_CYCLES  = 64,
    parameter int                SENSE_CYCLES = 16,
    parameter logic [NBANKS-1:0] WP_BANKS     = 8'h80,
    parameter logic [NBANKS-1:0] RP_BANKS     = 8'h40,
    parameter logic [NBANKS-1:0] OP_BANKS     = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic             busy, fin_prog, fin_sense, load_we, win_we;
    logic             start_prog, start_sense;
    logic [IDX_W-1:0] load_idx, win_idx, loc_idx, fuse_idx, sh_widx;
    logic [7:0]       fuse_rdata, sh_rdata, win_wdata, sh_wdata;
    logic [7:0]       key_q, ua_q, err_q;
    logic [1:0]       stat_q;
    fuse_loc_t        loc;

    assign loc_idx  = {loc.bank, loc.row};
    assign fuse_idx = load_we ? load_idx : loc_idx;
    assign sh_widx  = load_we ? load_idx : win_idx;
    assign sh_wdata = load_we ? fuse_rdata : win_wdata;

    fuse_seq #(
        .PROG_CYCLES (PROG_CYCLES),
        .SENSE_CYCLES(SENSE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_prog (start_prog),
        .start_sense(start_sense),
        .busy       (busy),
        .fin_prog   (fin_prog),
        .fin_sense  (fin_sense),
        .load_we    (load_we),
        .load_idx   (load_idx)
    );

    fuse_store u_store (
        .clk       (clk),
        .burn_en   (fin_prog),
        .burn_idx  (loc_idx),
        .burn_bit  (loc.bitn),
        .fuse_idx  (fuse_idx),
        .fuse_rdata(fuse_rdata),
        .sh_we     (load_we || win_we),
        .sh_widx   (sh_widx),
        .sh_wdata  (sh_wdata),
        .sh_ridx   (win_idx),
        .sh_rdata  (sh_rdata)
    );

    fuse_regs #(
        .WP_BANKS(WP_BANKS),
        .RP_BANKS(RP_BANKS),
        .OP_BANKS(OP_BANKS)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .fin_prog   (fin_prog),
        .fin_sense  (fin_sense),
        .fuse_word  (fuse_rdata),
        .sh_rdata   (sh_rdata),
        .start_prog (start_prog),
        .start_sense(start_sense),
        .loc        (loc),
        .win_we     (win_we),
        .win_idx    (win_idx),
        .win_wdata  (win_wdata),
        .key_q      (key_q),
        .ua_q       (ua_q),
        .stat_q     (stat_q),
        .err_q      (err_q)
    );
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk #(
    parameter int PROG_CYCLES  = 64,
    parameter int SENSE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       fin_prog,
    input logic       fin_sense,
    input logic [1:0] stat_q,
    input logic [7:0] err_q,
    input logic [7:0] key_q,
    input logic [7:0] ua_q
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_q <= '0;
        else              run_q <= run_q + 1;
    end

    // R3
    burn_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        fin_prog |-> key_q == 8'hAA);

    // R5
    prog_len_chk: assert property (@(posedge clk) disable iff (rst)
        fin_prog |-> run_q == 32'(PROG_CYCLES - 1));

    // R5
    sense_len_chk: assert property (@(posedge clk) disable iff (rst)
        fin_sense |-> run_q == 32'(SENSE_CYCLES - 1));

    // R5
    prog_done_chk: assert property (@(posedge clk) disable iff (rst)
        fin_prog |=> stat_q[1]);

    // R6
    sense_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        fin_sense |=> (stat_q[0] || err_q[2]));

    // R5
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[1]) |-> $past(fin_prog));

    // R12
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ua_q) && $stable(key_q));
endmodule

bind fuse_ctrl fuse_ctrl_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .SENSE_CYCLES(SENSE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .fin_prog (fin_prog),
    .fin_sense(fin_sense),
    .stat_q   (stat_q),
    .err_q    (err_q),
    .key_q    (key_q),
    .ua_q     (ua_q)
);

// File: tb/tb_fuse_ctrl.sv
module tb_fuse_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PROG_N    = 64;
    localparam int SENSE_N   = 16;
    localparam int LOAD_WAIT = 2048 + 16;

    localparam logic [11:0] A_STAT = 12'h000;
    localparam logic [11:0] A_ERR  = 12'h002;
    localparam logic [11:0] A_FCTL = 12'h004;
    localparam logic [11:0] A_UA   = 12'h005;
    localparam logic [11:0] A_LA   = 12'h006;
    localparam logic [11:0] A_SDAT = 12'h007;
    localparam logic [11:0] A_KEY  = 12'h008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;
    logic rd_q = 1'b0;

    logic [7:0] exp_val [$];
    string      exp_tag [$];

    always #4 clk = ~clk;

    fuse_ctrl #(
        .PROG_CYCLES (PROG_N),
        .SENSE_CYCLES(SENSE_N),
        .WP_BANKS    (8'h80),
        .RP_BANKS    (8'h40),
        .OP_BANKS    (8'h20)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [11:0] win(input int bank, input int word);
        return {1'b1, 3'(bank), 8'(word)};
    endfunction

    // monitor: compare read data one clock after each read strobe
    always @(posedge clk) rd_q <= bus_rd;

    always @(negedge clk) begin
        if (rd_q && exp_val.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_val.pop_front();
            t = exp_tag.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: got 0x%02h expected 0x%02h", t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic expect_read(input logic [11:0] a, input logic [7:0] e, input string t);
        exp_val.push_back(e);
        exp_tag.push_back(t);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        bus_write(A_STAT, 8'hFF);
        bus_write(A_ERR, 8'hFF);
    endtask

    task automatic do_sense(input logic [7:0] ua, input logic [7:0] la);
        bus_write(A_UA, ua);
        bus_write(A_LA, la);
        bus_write(A_FCTL, 8'h08);
        idle(SENSE_N + 3);
    endtask

    task automatic do_prog(input logic [7:0] ua, input logic [7:0] la);
        bus_write(A_UA, ua);
        bus_write(A_LA, la);
        bus_write(A_FCTL, 8'h01);
        idle(PROG_N + 3);
    endtask

    task automatic report();
        idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        idle(150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 loading phase then idle state
        expect_read(A_STAT, 8'h80, "R1 busy during load");
        idle(LOAD_WAIT);
        expect_read(A_STAT, 8'h00, "R1 status after load");
        expect_read(A_ERR, 8'h00, "R1 error after load");
        expect_read(win(0, 5), 8'h00, "R1 fresh shadow");

        // R8 override writes only the shadow
        bus_write(win(0, 5), 8'h3C);
        expect_read(win(0, 5), 8'h3C, "R8 override readback");

        // R3 no key: immediate program error, no busy
        bus_write(A_UA, 8'h11);
        bus_write(A_LA, 8'h0D);
        bus_write(A_FCTL, 8'h01);
        expect_read(A_STAT, 8'h00, "R3 no busy without key");
        expect_read(A_ERR, 8'h80, "R3 program error");
        bus_write(A_ERR, 8'h80);
        expect_read(A_ERR, 8'h00, "R11 error cleared");
        do_sense(8'h11, 8'h0D);
        expect_read(A_SDAT, 8'h00, "R3 array unchanged");
        clear_all();

        // R5 R12 program with key; writes during busy ignored
        bus_write(A_KEY, 8'hAA);
        bus_write(A_FCTL, 8'h01);
        expect_read(A_STAT, 8'h80, "R5 busy after start");
        bus_write(A_LA, 8'h0E);
        bus_write(A_KEY, 8'h00);
        bus_write(A_FCTL, 8'h08);
        bus_write(win(1, 1), 8'h99);
        idle(PROG_N);
        expect_read(A_STAT, 8'h02, "R12 program done, no sense started");
        expect_read(A_LA, 8'h0D, "R12 address held");
        expect_read(A_KEY, 8'hAA, "R12 key held");
        expect_read(win(1, 1), 8'h00, "R12 window write ignored");
        clear_all();

        // R5 R6 R2 exact sense timing and single-bit burn
        bus_write(A_FCTL, 8'h08);
        idle(SENSE_N - 1);
        expect_read(A_STAT, 8'h80, "R5 busy in last sense clock");
        expect_read(A_STAT, 8'h01, "R5 sense done");
        expect_read(A_SDAT, 8'h20, "R2 only bit 5 burned");
        do_sense(8'h10, 8'h0D);
        expect_read(A_SDAT, 8'h00, "R2 neighbour row clean");

        // R7 bits only set, repeat burn no change
        do_prog(8'h11, 8'h08);
        do_sense(8'h11, 8'h08);
        expect_read(A_SDAT, 8'h21, "R7 second bit added");
        do_prog(8'h11, 8'h0D);
        do_sense(8'h11, 8'h0D);
        expect_read(A_SDAT, 8'h21, "R7 reburn no change");
        clear_all();

        // R4 write-protected bank
        bus_write(A_UA, 8'h38);
        bus_write(A_LA, 8'h00);
        bus_write(A_FCTL, 8'h01);
        expect_read(A_ERR, 8'h40, "R4 write-protect error");
        expect_read(A_STAT, 8'h00, "R4 no busy");
        do_sense(8'h38, 8'h00);
        expect_read(A_SDAT, 8'h00, "R4 bank 7 unchanged");
        clear_all();

        // R9 read-protected window
        bus_write(win(6, 3), 8'h55);
        expect_read(win(6, 3), 8'h00, "R9 protected read gives zero");
        expect_read(A_ERR, 8'h10, "R9 read-protect error");
        clear_all();

        // R10 override-protected window
        bus_write(win(5, 2), 8'h77);
        expect_read(A_ERR, 8'h20, "R10 override-protect error");
        expect_read(win(5, 2), 8'h00, "R10 shadow unchanged");
        clear_all();

        // R6 sense of read-protected bank
        do_sense(8'h11, 8'h0D);
        clear_all();
        do_sense(8'h30, 8'h00);
        expect_read(A_STAT, 8'h00, "R6 no sense done");
        expect_read(A_ERR, 8'h04, "R6 sense error");
        expect_read(A_SDAT, 8'h21, "R6 sense data kept");
        clear_all();

        // R13 function register fields
        bus_write(A_FCTL, 8'h50);
        expect_read(A_FCTL, 8'h50, "R13 length field readback");
        expect_read(A_STAT, 8'h00, "R13 no cycle started");

        // R11 clear coincides with completion: set wins
        bus_write(A_UA, 8'h11);
        bus_write(A_LA, 8'h0D);
        bus_write(A_FCTL, 8'h01);
        idle(PROG_N - 1);
        bus_write(A_STAT, 8'h02);
        expect_read(A_STAT, 8'h02, "R11 set wins over clear");
        bus_write(A_STAT, 8'h02);
        expect_read(A_STAT, 8'h00, "R11 later clear works");

        // R1 R7 reset: fuses kept, shadow reloaded
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(LOAD_WAIT);
        expect_read(win(0, 5), 8'h00, "R1 override dropped by reload");
        expect_read(win(2, 8'h21), 8'h21, "R1 shadow loaded from fuses");
        expect_read(A_KEY, 8'h00, "R1 key reset");
        do_sense(8'h11, 8'h0D);
        expect_read(A_SDAT, 8'h21, "R7 burned bits survive reset");

        finished = 1'b1;
        report();
    end
endmodule